// File: doc/BRIEF.md
# Descriptor-Loaded Up/Down Counter with Single-Beat Memory Master

This block is an up/down counter whose start value and count direction come from a descriptor word held in memory, not from a local register. A small AXI4-Lite master fetches that word on command. The same master can also write the live count back to a fixed memory location. Each path uses one single-beat transaction, and only one transaction is in flight at any time.

Software, or a neighbouring register block, drives a two-bit trigger vector and an enable level. A rising edge on trigger bit 1 fetches the descriptor. A rising edge on trigger bit 0 stores the count. While enable is high the counter steps once per clock. The count is always visible on `count_out`. A busy level, a one-cycle done pulse and a sticky response-error flag report how each command went.

Top module: `desc_counter_top`

## Requirements
- R1: During and directly after reset, `count_out` is 0, the direction is up, `busy` and `resp_err` are 0, and every VALID and READY output of the master is 0.
- R2: While `count_en` is high and no descriptor is being loaded, `count_out` changes by one on every clock edge, modulo 256, in the current direction. While `count_en` is low it holds its value.
- R3: A rising edge on `cmd_trig[1]` issues one read at `BASE_ADDR + 0x204` with ARPROT 3'b001. When the R beat is accepted with RRESP[1] clear, `count_out` takes RDATA[7:0]. The direction becomes down if RDATA[8] is 1 and up if it is 0. RDATA bits 31:9 are ignored.
- R4: A rising edge on `cmd_trig[0]` issues one write at `BASE_ADDR + 0x200`. The data is the count, zero-extended to 32 bits, as it stood when the command was accepted. WSTRB is 4'b1111 and AWPROT is 3'b000.
- R5: AWVALID and WVALID rise in the same cycle, and each stays high until its own handshake. ARVALID stays high until ARREADY is seen.
- R6: BREADY and RREADY are one-cycle pulses, raised only after the matching VALID has been seen.
- R7: Commands start only on a low-to-high trigger transition. A trigger bit held high starts exactly one command.
- R8: `busy` is high from the cycle after a command is accepted until it completes. Completion gives a one-cycle `done` pulse. Trigger edges that arrive while busy are ignored, and only one of AWVALID and ARVALID is ever high.
- R9: When both trigger bits rise in the same cycle, only the write is performed.
- R10: `resp_err` is set when an accepted B or R beat has RESP[1] set. It stays set until the next command is accepted. An R beat with an error does not change the count or the direction.
- R11: Repeated commands always use the same two addresses. The offsets never advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_en | input | 1 | Counter step enable (level) |
| cmd_trig | input | 2 | Bit 0: store count; bit 1: fetch descriptor (edge triggered) |
| count_out | output | 8 | Live counter value |
| busy | output | 1 | A memory command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| resp_err | output | 1 | Last command got an error response |
| m_awaddr | output | 32 | Write address |
| m_awprot | output | 3 | Write protection, always 000 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobes, all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arprot | output | 3 | Read protection, always 001 |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
A sequencer that is stuck outside idle shows up as `busy` staying high with no `done`. It also shows up as later trigger edges producing no new address handshake, which the bench counts within a few cycles of each trigger. A wrong direction bit, or a descriptor load that should have been blocked, shows on `count_out` within the first enabled step after the fetch. A lost edge flop shows as a held trigger producing a second transaction, or no transaction at all. A corrupted capture register is caught at the responder, which records the write data and addresses in the same cycle as the handshake.

// File: rtl/dcm_pkg.sv
// Shared types and constants for the descriptor-loaded counter.
// Assumes: a single clock domain; every consumer imports this package.
package dcm_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STORE = 2'd1,
        SEQ_FETCH = 2'd2
    } seq_state_e;

    localparam logic [2:0] PROT_STORE = 3'b000;
    localparam logic [2:0] PROT_FETCH = 3'b001;

    localparam int TRIG_STORE_BIT = 0;
    localparam int TRIG_FETCH_BIT = 1;
endpackage

// File: rtl/trig_edge.sv
// Rising-edge detector for a vector of trigger levels.
// Each bit passes through two flops. The pulse is high for one cycle when the
// newer flop is high and the older flop is low.
// Assumes: the trigger inputs are already synchronous to clk.
module trig_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] pulse
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            logic cur_q;
            logic old_q;

            // Two-stage history of the trigger level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cur_q <= 1'b0;
                    old_q <= 1'b0;
                end else begin
                    cur_q <= lvl_in[gi];
                    old_q <= cur_q;
                end
            end

            assign pulse[gi] = cur_q & ~old_q;

            AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                pulse[gi] |=> !pulse[gi]); // R7
        end
    endgenerate
endmodule

// File: rtl/updn_counter.sv
// Wrapping up/down counter with a parallel load of value and direction.
// A load takes priority over counting. After reset the direction is up.
// Assumes: load is a one-cycle strobe.
module updn_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_down,
    output logic [W-1:0] count
);
    logic dir_down;

    // Count register and direction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dir_down <= 1'b0;
        end else if (load) begin
            count    <= load_val;
            dir_down <= load_down;
        end else if (en) begin
            count <= dir_down ? count - W'(1) : count + W'(1);
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !dir_down) |=> count == W'($past(count) + W'(1))); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && dir_down) |=> count == W'($past(count) - W'(1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count)); // R2
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val)); // R3
endmodule

// File: rtl/axil_cmd_master.sv
// Single-beat AXI4-Lite master that runs one store or one fetch at a time.
// A store writes the count captured at acceptance. A fetch reads the
// descriptor and strobes a load toward the counter when the response is OKAY.
// Assumes: store_req and fetch_req are one-cycle pulses. The slave holds
// each VALID until the matching READY is seen.
module axil_cmd_master
    import dcm_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 8,
    parameter logic [31:0] BASE_ADDR = 32'h0,
    parameter logic [31:0] STORE_OFS = 32'h200,
    parameter logic [31:0] DESC_OFS  = 32'h204
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                store_req,
    input  logic                fetch_req,
    input  logic [CNT_W-1:0]    count_val,
    output logic                busy,
    output logic                done,
    output logic                resp_err,
    output logic                desc_load,
    output logic [CNT_W-1:0]    desc_start,
    output logic                desc_down,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [2:0]          m_awprot,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [2:0]          m_arprot,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rvalid,
    output logic                m_rready
);
    localparam int STRB_W  = DATA_W / 8;
    localparam int DIR_BIT = CNT_W;

    seq_state_e state;
    logic       b_fire;
    logic       r_fire;
    logic       unused_bits;

    assign b_fire = m_bvalid && m_bready;
    assign r_fire = m_rvalid && m_rready;

    // Fixed addresses: base plus an offset that never advances
    assign m_awaddr = ADDR_W'(BASE_ADDR + STORE_OFS);
    assign m_araddr = ADDR_W'(BASE_ADDR + DESC_OFS);
    assign m_awprot = PROT_STORE;
    assign m_arprot = PROT_FETCH;
    assign m_wstrb  = {STRB_W{1'b1}};
    assign busy     = (state != SEQ_IDLE);

    // Descriptor decode toward the counter
    assign desc_load   = (state == SEQ_FETCH) && r_fire && !m_rresp[1];
    assign desc_start  = m_rdata[CNT_W-1:0];
    assign desc_down   = m_rdata[DIR_BIT];
    assign unused_bits = ^{m_rdata[DATA_W-1:DIR_BIT+1], m_bresp[0], m_rresp[0]};

    // Sequencer: idle, store or fetch, then back to idle with a done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            done     <= 1'b0;
            resp_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (store_req) begin
                        state    <= SEQ_STORE;
                        resp_err <= 1'b0;
                    end else if (fetch_req) begin
                        state    <= SEQ_FETCH;
                        resp_err <= 1'b0;
                    end
                end
                SEQ_STORE: begin
                    if (b_fire) begin
                        resp_err <= m_bresp[1];
                        done     <= 1'b1;
                        state    <= SEQ_IDLE;
                    end
                end
                SEQ_FETCH: begin
                    if (r_fire) begin
                        resp_err <= m_rresp[1];
                        done     <= 1'b1;
                        state    <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Write data capture at command acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_wdata <= '0;
        end else if (state == SEQ_IDLE && store_req) begin
            m_wdata <= DATA_W'(count_val);
        end
    end

    // Write address and data valids: raised together, dropped independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_awvalid <= 1'b0;
            m_wvalid  <= 1'b0;
        end else if (state == SEQ_IDLE && store_req) begin
            m_awvalid <= 1'b1;
            m_wvalid  <= 1'b1;
        end else begin
            if (m_awvalid && m_awready) m_awvalid <= 1'b0;
            if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
        end
    end

    // Write response ready: single-cycle pulse after BVALID is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_bready <= 1'b0;
        end else begin
            m_bready <= (state == SEQ_STORE) && m_bvalid && !m_bready;
        end
    end

    // Read address valid: raised on fetch acceptance, dropped on ARREADY
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_arvalid <= 1'b0;
        end else if (state == SEQ_IDLE && !store_req && fetch_req) begin
            m_arvalid <= 1'b1;
        end else if (m_arvalid && m_arready) begin
            m_arvalid <= 1'b0;
        end
    end

    // Read data ready: single-cycle pulse after RVALID is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_rready <= 1'b0;
        end else begin
            m_rready <= (state == SEQ_FETCH) && m_rvalid && !m_rready;
        end
    end

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> m_awvalid); // R5
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> m_wvalid); // R5
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> m_arvalid); // R5
    AST_AW_W_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $rose(m_wvalid)); // R5
    AST_BREADY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready |=> !m_bready); // R6
    AST_RREADY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_rready |=> !m_rready); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_awvalid && m_arvalid)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_err && !busy && !store_req && !fetch_req) |=> resp_err); // R10
endmodule

// File: rtl/desc_counter_top.sv
// Descriptor-loaded counter. Trigger edges start single-beat memory commands:
// bit 0 stores the count and bit 1 fetches the start value and direction.
// Assumes: the trigger and enable inputs are synchronous to clk, and the
// memory answers on an AXI4-Lite slave port.
module desc_counter_top #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 8,
    parameter logic [31:0] BASE_ADDR = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                count_en,
    input  logic [1:0]          cmd_trig,
    output logic [CNT_W-1:0]    count_out,
    output logic                busy,
    output logic                done,
    output logic                resp_err,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [2:0]          m_awprot,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [2:0]          m_arprot,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rvalid,
    output logic                m_rready
);
    import dcm_pkg::*;

    localparam int TRIG_N = 2;

    logic [TRIG_N-1:0] trig_pulse;
    logic              ld_strobe;
    logic [CNT_W-1:0]  ld_value;
    logic              ld_down;

    trig_edge #(.N(TRIG_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (cmd_trig),
        .pulse  (trig_pulse)
    );

    axil_cmd_master #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_req  (trig_pulse[TRIG_STORE_BIT]),
        .fetch_req  (trig_pulse[TRIG_FETCH_BIT]),
        .count_val  (count_out),
        .busy       (busy),
        .done       (done),
        .resp_err   (resp_err),
        .desc_load  (ld_strobe),
        .desc_start (ld_value),
        .desc_down  (ld_down),
        .m_awaddr   (m_awaddr),
        .m_awprot   (m_awprot),
        .m_awvalid  (m_awvalid),
        .m_awready  (m_awready),
        .m_wdata    (m_wdata),
        .m_wstrb    (m_wstrb),
        .m_wvalid   (m_wvalid),
        .m_wready   (m_wready),
        .m_bresp    (m_bresp),
        .m_bvalid   (m_bvalid),
        .m_bready   (m_bready),
        .m_araddr   (m_araddr),
        .m_arprot   (m_arprot),
        .m_arvalid  (m_arvalid),
        .m_arready  (m_arready),
        .m_rdata    (m_rdata),
        .m_rresp    (m_rresp),
        .m_rvalid   (m_rvalid),
        .m_rready   (m_rready)
    );

    updn_counter #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (count_en),
        .load      (ld_strobe),
        .load_val  (ld_value),
        .load_down (ld_down),
        .count     (count_out)
    );

    AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && m_rready && m_rresp[1] && !count_en) |=> $stable(count_out)); // R10
endmodule

// File: tb/desc_counter_top_bench.sv
module desc_counter_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0;
    logic [1:0]  cmd_trig = 2'b00;
    logic [7:0]  count_out;
    logic        busy, done, resp_err;
    logic [31:0] m_awaddr, m_wdata, m_araddr;
    logic [31:0] m_rdata = '0;
    logic [2:0]  m_awprot, m_arprot;
    logic [3:0]  m_wstrb;
    logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic        m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic        m_arready = 1'b0, m_rvalid = 1'b0;
    logic [1:0]  m_bresp = '0, m_rresp = '0;

    always #5 clk = ~clk;

    desc_counter_top u_desc_counter_top (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .cmd_trig(cmd_trig),
        .count_out(count_out), .busy(busy), .done(done), .resp_err(resp_err),
        .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    // Responder configuration and captured traffic
    logic [31:0] desc_word = '0, store_word = '0;
    logic [1:0]  resp_cfg = 2'b00;
    int          stall_cfg = 0;
    logic [31:0] cap_awaddr = '0, cap_wdata = '0, cap_araddr = '0;
    logic [2:0]  cap_awprot = '0, cap_arprot = '0;
    logic [3:0]  cap_wstrb = '0;
    logic        aw_got = 0, w_got = 0, ar_got = 0;
    int          aw_age = 0, w_age = 0, ar_age = 0;
    int          aw_cnt = 0, ar_cnt = 0;
    int          n_chk = 0, n_err = 0;
    int          v_hold = 0, v_pair = 0, v_pulse = 0;

    localparam logic [31:0] V_DESC [5] = '{32'h0000_0010, 32'h0000_0103, 32'hFFFF_FEFD, 32'h0000_01F0, 32'hABCD_0180};
    localparam logic [1:0]  V_RESP [5] = '{2'b00, 2'b00, 2'b00, 2'b10, 2'b00};
    localparam logic [7:0]  V_LOAD [5] = '{8'h10, 8'h03, 8'hFD, 8'h01, 8'h80};
    localparam int          V_STEP [5] = '{5, 5, 4, 3, 2};
    localparam logic [7:0]  V_AFTR [5] = '{8'h15, 8'hFE, 8'h01, 8'h04, 8'h7E};
    localparam logic        V_ERR  [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    // Simple memory responder with a configurable READY delay
    initial forever begin
        @(posedge clk);
        if (!rst_n) begin
            m_awready <= 0; m_wready <= 0; m_bvalid <= 0; m_arready <= 0; m_rvalid <= 0;
            aw_got <= 0; w_got <= 0; ar_got <= 0; aw_age <= 0; w_age <= 0; ar_age <= 0;
        end else begin
            aw_age <= (m_awvalid && !aw_got) ? aw_age + 1 : 0;
            w_age  <= (m_wvalid && !w_got) ? w_age + 1 : 0;
            ar_age <= (m_arvalid && !ar_got) ? ar_age + 1 : 0;
            m_awready <= m_awvalid && !m_awready && !aw_got && aw_age >= stall_cfg;
            m_wready  <= m_wvalid && !m_wready && !w_got && w_age >= stall_cfg;
            m_arready <= m_arvalid && !m_arready && !ar_got && ar_age >= stall_cfg;
            if (m_awvalid && m_awready) begin
                aw_got <= 1; cap_awaddr <= m_awaddr; cap_awprot <= m_awprot; aw_cnt <= aw_cnt + 1;
            end
            if (m_wvalid && m_wready) begin
                w_got <= 1; cap_wdata <= m_wdata; cap_wstrb <= m_wstrb;
            end
            if (aw_got && w_got && !m_bvalid) begin
                m_bvalid <= 1; m_bresp <= resp_cfg; aw_got <= 0; w_got <= 0;
                if (cap_awaddr == 32'h200) store_word <= cap_wdata;
            end
            if (m_bvalid && m_bready) m_bvalid <= 0;
            if (m_arvalid && m_arready) begin
                ar_got <= 1; cap_araddr <= m_araddr; cap_arprot <= m_arprot; ar_cnt <= ar_cnt + 1;
            end
            if (ar_got && !m_rvalid) begin
                m_rvalid <= 1; m_rresp <= resp_cfg; ar_got <= 0;
                m_rdata <= (cap_araddr == 32'h204) ? desc_word :
                           (cap_araddr == 32'h200) ? store_word : 32'hDEAD_BEEF;
            end
            if (m_rvalid && m_rready) m_rvalid <= 0;
        end
    end

    // Protocol monitor sampled between edges (R5, R6)
    initial begin
        logic p_awv, p_awr, p_wv, p_wr, p_arv, p_arr, p_br, p_rr;
        p_awv = 0; p_awr = 0; p_wv = 0; p_wr = 0; p_arv = 0; p_arr = 0; p_br = 0; p_rr = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (p_awv && !p_awr && !m_awvalid) v_hold++;
                if (p_wv && !p_wr && !m_wvalid) v_hold++;
                if (p_arv && !p_arr && !m_arvalid) v_hold++;
                if ((!p_awv && m_awvalid) != (!p_wv && m_wvalid)) v_pair++;
                if ((p_br && m_bready) || (p_rr && m_rready)) v_pulse++;
            end
            p_awv = m_awvalid; p_awr = m_awready; p_wv = m_wvalid; p_wr = m_wready;
            p_arv = m_arvalid; p_arr = m_arready; p_br = m_bready; p_rr = m_rready;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk("R8 done never seen", 0, 1);
    endtask

    task automatic pulse_trig(input logic [1:0] bits);
        @(negedge clk) cmd_trig = bits;
        @(negedge clk) cmd_trig = 2'b00;
    endtask

    task automatic run_en(input int n);
        @(negedge clk) count_en = 1;
        repeat (n) @(negedge clk);
        count_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int aw0, ar0;
        repeat (4) @(negedge clk);
        // R1: state while and just after reset
        chk("R1 count", count_out, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", resp_err, 0);
        chk("R1 valids", {m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {count_out, busy}, 0);

        // R2: counts up from reset, holds when disabled
        run_en(3);
        chk("R2 up from reset", count_out, 8'h03);
        repeat (4) @(negedge clk);
        chk("R2 hold", count_out, 8'h03);

        // R3 / R10 / R2: descriptor table
        for (int v = 0; v < 5; v++) begin
            desc_word = V_DESC[v];
            resp_cfg = V_RESP[v];
            pulse_trig(2'b10);
            wait_done();
            chk("R3 loaded value", count_out, V_LOAD[v]);
            chk("R10 err flag", resp_err, V_ERR[v]);
            chk("R3 read addr", cap_araddr, 32'h204);
            chk("R3 arprot", cap_arprot, 3'b001);
            resp_cfg = 2'b00;
            run_en(V_STEP[v]);
            chk("R2 R3 after steps", count_out, V_AFTR[v]);
        end

        // R4: store the count (0x7E, direction down)
        pulse_trig(2'b01);
        wait_done();
        chk("R4 addr", cap_awaddr, 32'h200);
        chk("R4 data", cap_wdata, 32'h0000_007E);
        chk("R4 strb", cap_wstrb, 4'hF);
        chk("R4 awprot", cap_awprot, 3'b000);
        chk("R4 memory", store_word, 32'h7E);
        chk("R4 err", resp_err, 0);

        // R11: second store uses the same address
        run_en(2);
        stall_cfg = 3;
        pulse_trig(2'b01);
        wait_done();
        chk("R11 addr repeat", cap_awaddr, 32'h200);
        chk("R11 data", cap_wdata, 32'h7C);

        // R10: write error sticks until next command
        resp_cfg = 2'b10;
        pulse_trig(2'b01);
        wait_done();
        chk("R10 B error", resp_err, 1);
        resp_cfg = 2'b00;
        repeat (5) @(negedge clk);
        chk("R10 sticky", resp_err, 1);
        desc_word = 32'h0000_0022;
        pulse_trig(2'b10);
        wait_done();
        chk("R10 cleared", resp_err, 0);
        chk("R3 load after err", count_out, 8'h22);

        // R7: a held trigger starts one command only
        ar0 = ar_cnt;
        @(negedge clk) cmd_trig = 2'b10;
        wait_done();
        repeat (10) @(negedge clk);
        chk("R7 held trigger", ar_cnt, ar0 + 1);
        cmd_trig = 2'b00;
        pulse_trig(2'b10);
        wait_done();
        chk("R7 new edge", ar_cnt, ar0 + 2);

        // R8: edges while busy are ignored
        stall_cfg = 5;
        aw0 = aw_cnt;
        pulse_trig(2'b10);
        @(negedge clk);
        chk("R8 busy", busy, 1);
        cmd_trig = 2'b01;
        @(negedge clk) cmd_trig = 2'b00;
        wait_done();
        chk("R8 idle at done", busy, 0);
        repeat (10) @(negedge clk);
        chk("R8 ignored store", aw_cnt, aw0);

        // R9: simultaneous edges, write wins
        stall_cfg = 4;
        aw0 = aw_cnt; ar0 = ar_cnt;
        pulse_trig(2'b11);
        wait_done();
        repeat (10) @(negedge clk);
        chk("R9 write done", aw_cnt, aw0 + 1);
        chk("R9 no read", ar_cnt, ar0);

        chk("R5 valid hold", v_hold, 0);
        chk("R5 aw w together", v_pair, 0);
        chk("R6 ready pulse", v_pulse, 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule